// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds fourteen sixteen-bit registers: eight general and pointer registers, the instruction pointer, four segment registers and a status word. Four of the general registers can also be addressed as two independent eight-bit halves, so code written for an eight-bit machine can run against the same storage. Two combinational read ports and one write port each take a four-bit register index and an operand-size bit (byte or word). The index is read as a byte index or a word index according to that bit.

A small adder sits beside the file. When the add strobe is high, it sums the two read-port values at the operand size of the write port and writes the sum back to the write-port destination. The sum is cut to the operand width. The bit that is lost goes out on a carry output and is stored into bit 0 of the status word on the same clock edge. Byte writes use per-half write enables, so a byte operation can never disturb the other half of its register or carry into it.

Top module: `bytealias_regfile`

## Requirements
- R1: After reset is released, every register reads 0x0000 and `carry_o` is 0.
- R2: Word index decoding (size bit 0): 0=AX, 1=CX, 2=DX, 3=BX, 4=SP, 5=BP, 6=SI, 7=DI, 8=IP, 9=ES, 10=CS, 11=SS, 12=DS, 13=status word. A word write stores all 16 bits of `wr_data` at the clock edge, and a word read returns all 16 bits.
- R3: Byte index decoding (size bit 1): 0=AL, 1=CL, 2=DL, 3=BL (bits 7:0 of AX, CX, DX, BX), 4=AH, 5=CH, 6=DH, 7=BH (bits 15:8 of the same registers). A byte read places the selected half on data bits 7:0 and drives bits 15:8 to zero.
- R4: A byte write to a low half stores `wr_data[7:0]` into bits 7:0 and leaves bits 15:8 of that register unchanged.
- R5: A byte write to a high half stores `wr_data[7:0]` into bits 15:8 and leaves bits 7:0 of that register unchanged.
- R6: When `add_en` is 1, the sum of the two read-port values is written to the register selected by `wr_idx`/`wr_byte`. In this case `wr_data` and `wr_en` are ignored. A word add keeps the low 16 bits of the sum (0x8226 + 0x8226 leaves 0x044C), and the carry is sum bit 16.
- R7: A byte add keeps the low 8 bits of the sum, and the carry is sum bit 8. The carry never reaches the other half of the destination.
- R8: `carry_o` is 0 whenever `add_en` is 0. While `add_en` is 1, it shows the bit lost by the add in the same cycle.
- R9: On the clock edge of every add, bit 0 of the status word takes the value of `carry_o`. The other status bits are unchanged unless the status word is itself the destination. If the status word is the destination, bit 0 still takes the carry.
- R10: A read of the register being written in the same cycle returns the value from before the write. The new value is visible from the next cycle.
- R11: Word indices 14 and 15, and byte indices 8 to 15, read as 0x0000. A write or add to such an index changes no general register.
- R12: The two read ports decode their index and size independently. In the same cycle they can return different registers at different sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears every register |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_byte | input | 1 | Read port A size: 1 byte, 0 word |
| rd_a_data | output | 16 | Read port A data, zero-extended for bytes |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_byte | input | 1 | Read port B size: 1 byte, 0 word |
| rd_b_data | output | 16 | Read port B data, zero-extended for bytes |
| wr_en | input | 1 | Write `wr_data` at the clock edge |
| add_en | input | 1 | Write the sum of both read ports instead of `wr_data` |
| wr_idx | input | 4 | Destination register index |
| wr_byte | input | 1 | Destination and add size: 1 byte, 0 word |
| wr_data | input | 16 | Write data, only bits 7:0 used for bytes |
| carry_o | output | 1 | Bit lost by the current add |

## Verification
A wrong half-register enable or a wrong decode shows at the read ports one cycle after the write, as a changed neighbour byte or a value landing in the wrong register. The bench therefore reads back both the target and its sibling half after every byte operation. A carry that leaks across the byte boundary, or a missing truncation, shows in the word read of the destination the cycle after the add. An error in the status latch shows in bit 0 of the status word in that same cycle. A read port that returns data after the write instead of before it is caught within the write cycle itself.

// File: rtl/bytealias_rf_pkg.sv
package bytealias_rf_pkg;

  localparam int WORD_W = 16;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [3:0] {
    SLOT_AX = 4'd0, SLOT_CX = 4'd1, SLOT_DX = 4'd2, SLOT_BX = 4'd3,
    SLOT_SP = 4'd4, SLOT_BP = 4'd5, SLOT_SI = 4'd6, SLOT_DI = 4'd7,
    SLOT_IP = 4'd8, SLOT_ES = 4'd9, SLOT_CS = 4'd10, SLOT_SS = 4'd11,
    SLOT_DS = 4'd12, SLOT_ST = 4'd13
  } slot_e;

  // Sum of two operands cut to the operand width; the top bit returned is
  // the bit that did not fit.
  function automatic logic [WORD_W:0] add_trunc(input logic [WORD_W-1:0] a,
                                                input logic [WORD_W-1:0] b,
                                                input logic              is_byte);
    logic [WORD_W:0] full;
    full = {1'b0, a} + {1'b0, b};
    if (is_byte)
      return {full[HALF_W], {HALF_W{1'b0}}, full[HALF_W-1:0]};
    return full;
  endfunction

  function automatic logic [WORD_W-1:0] zext_half(input logic [HALF_W-1:0] h);
    return {{HALF_W{1'b0}}, h};
  endfunction

  // Copy a byte onto both halves; the byte enables pick the half that lands.
  function automatic logic [WORD_W-1:0] spread_half(input logic [HALF_W-1:0] h);
    return {h, h};
  endfunction

endpackage

// File: rtl/bytealias_locate.sv
module bytealias_locate #(
  parameter int IDX_W     = 4,
  parameter int NUM_REGS  = 14,
  parameter int NUM_SPLIT = 4,
  localparam int SLOT_W   = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic              is_byte,
  output logic              valid,
  output logic [SLOT_W-1:0] slot,
  output logic              hi
);

  always_comb begin
    valid = 1'b0;
    slot  = '0;
    hi    = 1'b0;
    if (is_byte) begin
      if (int'(idx) < 2 * NUM_SPLIT) begin
        valid = 1'b1;
        hi    = (int'(idx) >= NUM_SPLIT);
        slot  = hi ? SLOT_W'(int'(idx) - NUM_SPLIT) : SLOT_W'(idx);
      end
    end else if (int'(idx) < NUM_REGS) begin
      valid = 1'b1;
      slot  = SLOT_W'(idx);
    end
  end

endmodule

// File: rtl/bytealias_rdport.sv
module bytealias_rdport
  import bytealias_rf_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int NUM_REGS  = 14,
  parameter int NUM_SPLIT = 4
) (
  input  logic [NUM_REGS-1:0][WORD_W-1:0] regs_q,
  input  logic [IDX_W-1:0]                idx,
  input  logic                            is_byte,
  output logic [WORD_W-1:0]               data
);

  localparam int SLOT_W = $clog2(NUM_REGS);

  logic              loc_valid;
  logic [SLOT_W-1:0] loc_slot;
  logic              loc_hi;
  logic [WORD_W-1:0] word_sel;

  bytealias_locate #(
    .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .NUM_SPLIT(NUM_SPLIT)
  ) u_loc (
    .idx(idx), .is_byte(is_byte),
    .valid(loc_valid), .slot(loc_slot), .hi(loc_hi)
  );

  assign word_sel = loc_valid ? regs_q[loc_slot] : '0;

  always_comb begin
    if (!is_byte)
      data = word_sel;
    else if (loc_hi)
      data = zext_half(word_sel[WORD_W-1:HALF_W]);
    else
      data = zext_half(word_sel[HALF_W-1:0]);
  end

endmodule

// File: rtl/bytealias_adder.sv
module bytealias_adder
  import bytealias_rf_pkg::*;
(
  input  logic              en,
  input  logic              is_byte,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  output logic [WORD_W-1:0] sum,
  output logic              carry
);

  logic [WORD_W:0] packed_sum;

  assign packed_sum = add_trunc(opa, opb, is_byte);
  assign sum        = packed_sum[WORD_W-1:0];
  assign carry      = en & packed_sum[WORD_W];

endmodule

// File: rtl/bytealias_store.sv
module bytealias_store
  import bytealias_rf_pkg::*;
#(
  parameter int NUM_REGS    = 14,
  parameter int STATUS_SLOT = NUM_REGS - 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_REGS-1:0]             lo_we,
  input  logic [NUM_REGS-1:0]             hi_we,
  input  logic [WORD_W-1:0]               wdata,
  input  logic                            flag_we,
  input  logic                            flag_val,
  output logic [NUM_REGS-1:0][WORD_W-1:0] regs_q
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g][WORD_W-1:HALF_W] <= '0;
      end else if (hi_we[g]) begin
        regs_q[g][WORD_W-1:HALF_W] <= wdata[WORD_W-1:HALF_W];
      end
    end

    if (g == STATUS_SLOT) begin : g_status
      // Bit 0 holds the add carry and wins over a plain write.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs_q[g][HALF_W-1:0] <= '0;
        end else begin
          if (lo_we[g]) regs_q[g][HALF_W-1:1] <= wdata[HALF_W-1:1];
          if (flag_we)       regs_q[g][0] <= flag_val;
          else if (lo_we[g]) regs_q[g][0] <= wdata[0];
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs_q[g][HALF_W-1:0] <= '0;
        end else if (lo_we[g]) begin
          regs_q[g][HALF_W-1:0] <= wdata[HALF_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/bytealias_regfile.sv
module bytealias_regfile
  import bytealias_rf_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int NUM_REGS  = 14,
  parameter int NUM_SPLIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic              rd_a_byte,
  output logic [WORD_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  input  logic              rd_b_byte,
  output logic [WORD_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic              add_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_byte,
  input  logic [WORD_W-1:0] wr_data,
  output logic              carry_o
);

  localparam int SLOT_W  = $clog2(NUM_REGS);
  localparam int NUM_RD  = 2;

  logic [NUM_REGS-1:0][WORD_W-1:0] regs_q;

  // Read ports
  logic [IDX_W-1:0]  rp_idx  [NUM_RD];
  logic              rp_byte [NUM_RD];
  logic [WORD_W-1:0] rp_data [NUM_RD];

  assign rp_idx[0]  = rd_a_idx;
  assign rp_byte[0] = rd_a_byte;
  assign rp_idx[1]  = rd_b_idx;
  assign rp_byte[1] = rd_b_byte;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    bytealias_rdport #(
      .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .NUM_SPLIT(NUM_SPLIT)
    ) u_rd (
      .regs_q(regs_q), .idx(rp_idx[p]), .is_byte(rp_byte[p]), .data(rp_data[p])
    );
  end

  assign rd_a_data = rp_data[0];
  assign rd_b_data = rp_data[1];

  // Add datapath
  logic [WORD_W-1:0] add_sum;
  logic              add_carry;

  bytealias_adder u_add (
    .en(add_en), .is_byte(wr_byte),
    .opa(rp_data[0]), .opb(rp_data[1]),
    .sum(add_sum), .carry(add_carry)
  );

  assign carry_o = add_carry;

  // Write decode, brought out as named events for the checker
  logic              wloc_valid;
  logic [SLOT_W-1:0] wr_slot;
  logic              wloc_hi;
  logic              wr_valid;
  logic [1:0]        wr_hmask;
  logic [WORD_W-1:0] wr_src;
  logic [WORD_W-1:0] wr_aligned;
  logic [NUM_REGS-1:0] lo_we;
  logic [NUM_REGS-1:0] hi_we;

  bytealias_locate #(
    .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .NUM_SPLIT(NUM_SPLIT)
  ) u_wloc (
    .idx(wr_idx), .is_byte(wr_byte),
    .valid(wloc_valid), .slot(wr_slot), .hi(wloc_hi)
  );

  assign wr_valid   = (wr_en | add_en) & wloc_valid;
  assign wr_hmask   = !wr_byte ? 2'b11 : (wloc_hi ? 2'b10 : 2'b01);
  assign wr_src     = add_en ? add_sum : wr_data;
  assign wr_aligned = wr_byte ? spread_half(wr_src[HALF_W-1:0]) : wr_src;
  assign lo_we      = (wr_valid && wr_hmask[0]) ? (NUM_REGS'(1) << wr_slot) : '0;
  assign hi_we      = (wr_valid && wr_hmask[1]) ? (NUM_REGS'(1) << wr_slot) : '0;

  bytealias_store #(
    .NUM_REGS(NUM_REGS), .STATUS_SLOT(NUM_REGS - 1)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .lo_we(lo_we), .hi_we(hi_we), .wdata(wr_aligned),
    .flag_we(add_en), .flag_val(add_carry),
    .regs_q(regs_q)
  );

endmodule

// File: rtl/bytealias_regfile_chk.sv
module bytealias_regfile_chk
  import bytealias_rf_pkg::*;
#(
  parameter int NUM_REGS = 14,
  localparam int SLOT_W  = $clog2(NUM_REGS)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            add_en,
  input logic                            carry_o,
  input logic                            rd_a_byte,
  input logic [WORD_W-1:0]               rd_a_data,
  input logic                            rd_b_byte,
  input logic [WORD_W-1:0]               rd_b_data,
  input logic                            wr_valid,
  input logic [SLOT_W-1:0]               wr_slot,
  input logic [1:0]                      wr_hmask,
  input logic [NUM_REGS-1:0][WORD_W-1:0] regs_q
);

  // R3
  byte_read_zext_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_byte |-> rd_a_data[WORD_W-1:HALF_W] == '0);

  // R3
  byte_read_zext_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_byte |-> rd_b_data[WORD_W-1:HALF_W] == '0);

  // R4
  lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_hmask == 2'b01) |=>
      regs_q[$past(wr_slot)][WORD_W-1:HALF_W] == $past(regs_q[wr_slot][WORD_W-1:HALF_W]));

  // R5
  hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_hmask == 2'b10) |=>
      regs_q[$past(wr_slot)][HALF_W-1:0] == $past(regs_q[wr_slot][HALF_W-1:0]));

  // R8
  no_carry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en |-> !carry_o);

  // R9
  carry_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> regs_q[NUM_REGS-1][0] == $past(carry_o));

  // R11
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !add_en) |=> $stable(regs_q));

endmodule

bind bytealias_regfile bytealias_regfile_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .add_en(add_en), .carry_o(carry_o),
  .rd_a_byte(rd_a_byte), .rd_a_data(rd_a_data),
  .rd_b_byte(rd_b_byte), .rd_b_data(rd_b_data),
  .wr_valid(wr_valid), .wr_slot(wr_slot), .wr_hmask(wr_hmask),
  .regs_q(regs_q)
);

// File: tb/bytealias_regfile_tb.sv
`timescale 1ns/1ps
module bytealias_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic        rd_a_byte = 1'b0, rd_b_byte = 1'b0, wr_byte = 1'b0;
  logic [15:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, add_en = 1'b0;
  logic        carry_o;

  always #2.5 clk = ~clk;

  bytealias_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_byte(rd_a_byte), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_byte(rd_b_byte), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .add_en(add_en), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .wr_data(wr_data), .carry_o(carry_o)
  );

  // Bench model of the register contents, written from the requirements.
  logic [15:0] mdl [14];

  typedef struct { int sel; logic [15:0] exp; string tag; } item_t;
  item_t sbq [$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  event  sample_ev;

  function automatic logic [15:0] m_read(int idx, bit byt);
    if (byt) begin
      if (idx < 4) return {8'h00, mdl[idx][7:0]};
      if (idx < 8) return {8'h00, mdl[idx-4][15:8]};
      return 16'h0000;
    end
    if (idx < 14) return mdl[idx];
    return 16'h0000;
  endfunction

  function automatic void m_write(int idx, bit byt, logic [15:0] d);
    if (byt) begin
      if (idx < 4)      mdl[idx][7:0]     = d[7:0];
      else if (idx < 8) mdl[idx-4][15:8]  = d[7:0];
    end else if (idx < 14) begin
      mdl[idx] = d;
    end
  endfunction

  task automatic push(int sel, logic [15:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Monitor: pops expected items and compares them with the ports.
  initial begin
    item_t       it;
    logic [15:0] act;
    forever begin
      @(sample_ev);
      while (sbq.size() > 0) begin
        it = sbq.pop_front();
        case (it.sel)
          0:       act = rd_a_data;
          1:       act = rd_b_data;
          default: act = {15'b0, carry_o};
        endcase
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic check_val(bit port, int idx, bit byt, logic [15:0] exp, string tag);
    @(negedge clk);
    if (port) begin rd_b_idx = 4'(idx); rd_b_byte = byt; end
    else      begin rd_a_idx = 4'(idx); rd_a_byte = byt; end
    #1;
    push(int'(port), exp, tag);
    ->sample_ev;
  endtask

  task automatic check_rd(bit port, int idx, bit byt, string tag);
    check_val(port, idx, byt, m_read(idx, byt), tag);
  endtask

  task automatic check_pair(int ia, bit ba, int ib, bit bb, string tag);
    @(negedge clk);
    rd_a_idx = 4'(ia); rd_a_byte = ba;
    rd_b_idx = 4'(ib); rd_b_byte = bb;
    #1;
    push(0, m_read(ia, ba), tag);
    push(1, m_read(ib, bb), tag);
    ->sample_ev;
  endtask

  task automatic wr(int idx, bit byt, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; add_en = 1'b0;
    wr_idx = 4'(idx); wr_byte = byt; wr_data = d;
    @(posedge clk);
    m_write(idx, byt, d);
    #1 wr_en = 1'b0;
  endtask

  task automatic do_add(int ai, bit ab, int bi, bit bb, int di, bit db, string tag);
    logic [16:0] full;
    logic [15:0] res;
    logic        cy;
    @(negedge clk);
    rd_a_idx = 4'(ai); rd_a_byte = ab;
    rd_b_idx = 4'(bi); rd_b_byte = bb;
    wr_idx = 4'(di); wr_byte = db; wr_data = 16'hDEAD;
    wr_en = 1'b0; add_en = 1'b1;
    full = {1'b0, m_read(ai, ab)} + {1'b0, m_read(bi, bb)};
    cy   = db ? full[8] : full[16];
    res  = db ? {8'h00, full[7:0]} : full[15:0];
    #1;
    push(2, {15'b0, cy}, tag);
    ->sample_ev;
    @(posedge clk);
    m_write(di, db, res);
    mdl[13][0] = cy;
    #1 add_en = 1'b0;
  endtask

  task automatic rd_during_wr(int idx, logic [15:0] d, string tag);
    @(negedge clk);
    rd_a_idx = 4'(idx); rd_a_byte = 1'b0;
    wr_en = 1'b1; wr_idx = 4'(idx); wr_byte = 1'b0; wr_data = d;
    #1;
    push(0, mdl[idx], tag);
    ->sample_ev;
    @(posedge clk);
    m_write(idx, 1'b0, d);
    #1 wr_en = 1'b0;
    check_rd(0, idx, 0, tag);
  endtask

  task automatic summary();
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 14; i++) mdl[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 14; i++) check_val(0, i, 0, 16'h0000, "R1 reset value");
    @(negedge clk); #1 push(2, 16'h0000, "R1 carry after reset"); ->sample_ev;

    // R2: word write and read of every register through both ports
    for (int i = 0; i < 14; i++) begin
      wr(i, 0, 16'h1000 + 16'(i) * 16'h0111);
      check_rd(0, i, 0, "R2 word port A");
      check_rd(1, i, 0, "R2 word port B");
    end

    // R3: byte aliasing map
    wr(0, 0, 16'h1234);
    wr(3, 0, 16'hABCD);
    for (int i = 0; i < 8; i++) check_rd(0, i, 1, "R3 byte read port A");
    check_val(1, 4, 1, 16'h0012, "R3 AH on port B");
    check_val(1, 3, 1, 16'h00CD, "R3 BL on port B");

    // R12: independent ports, mixed sizes
    check_pair(7, 1, 2, 0, "R12 BH and DX together");
    check_pair(13, 0, 1, 1, "R12 status and CL together");

    // R4: low half write keeps high half
    wr(0, 1, 16'h55FF);
    check_val(0, 0, 0, 16'h12FF, "R4 AL write keeps AH");
    // R5: high half write keeps low half
    wr(7, 1, 16'hEE77);
    check_val(0, 3, 0, 16'h77CD, "R5 BH write keeps BL");
    wr(5, 1, 16'h0099);
    check_rd(0, 1, 0, "R5 CH write keeps CL");

    // R6 and R9: word add truncation and carry latch
    wr(13, 0, 16'hFFFE);
    wr(0, 0, 16'h8226);
    wr(3, 0, 16'h8226);
    do_add(0, 0, 3, 0, 0, 0, "R6 word add carry");
    check_val(0, 0, 0, 16'h044C, "R6 word add truncated");
    check_val(0, 13, 0, 16'hFFFF, "R9 status bit0 set by carry");
    check_val(0, 3, 0, 16'h8226, "R6 source BX unchanged");

    // R8: idle carry and an add with no overflow
    @(negedge clk); #1 push(2, 16'h0000, "R8 carry idle"); ->sample_ev;
    do_add(1, 0, 2, 0, 1, 0, "R8 no-overflow carry");
    check_rd(0, 1, 0, "R8 no-overflow sum");
    check_val(0, 13, 0, 16'hFFFE, "R9 status bit0 cleared by add");

    // R7: byte add, carry must not reach the high half
    wr(0, 1, 16'h00FF);
    wr(3, 1, 16'h0001);
    do_add(0, 1, 3, 1, 0, 1, "R7 byte add carry");
    check_val(0, 0, 0, 16'h0400, "R7 AL wraps, AH unchanged");
    check_val(0, 13, 0, 16'hFFFF, "R9 status after byte carry");
    do_add(4, 1, 7, 1, 5, 1, "R7 high-byte add carry");
    check_rd(0, 1, 0, "R7 high-byte add into CH keeps CL");

    // R10: read during write returns the old value
    rd_during_wr(2, 16'hBEEF, "R10 read during write");
    rd_during_wr(8, 16'h0F0F, "R10 read during write IP");

    // R11: unused indices
    check_val(0, 14, 0, 16'h0000, "R11 word index 14");
    check_val(1, 15, 0, 16'h0000, "R11 word index 15");
    check_val(0, 8, 1, 16'h0000, "R11 byte index 8");
    check_val(1, 12, 1, 16'h0000, "R11 byte index 12");
    wr(14, 0, 16'hFFFF);
    wr(9, 1, 16'h00AA);
    for (int i = 0; i < 14; i++) check_rd(0, i, 0, "R11 invalid write ignored");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule